// File: doc/BRIEF.md
# Sign-Magnitude Four-Term Adder Tree

This block adds four signed fixed-point operands that arrive together, flagged by a single-cycle valid strobe. Every operand and the result use sign-magnitude coding. The two pairs (A,B) and (C,D) are each combined by a two-input adder that looks at the operand signs. Those two partial sums are then combined by a third adder of the same kind. Each of the two adder levels ends in a register, so the result appears with a one-cycle done strobe.

The adder treats three sign cases separately:
- When both signs match, it adds the magnitudes.
- When the signs differ, it subtracts the smaller magnitude from the larger one.
- A result of zero always carries a positive sign.

Magnitude overflow wraps and does not saturate. The block fits after a bank of multipliers whose products need to be summed without converting them to two's complement.

Top module: `sm_sum4`

## Requirements
- R1: Every operand and the result is W bits wide (default 32). Bit W-1 is the sign (1 = negative) and bits W-2:0 are the unsigned magnitude.
- R2: When both operands of a two-input adder have the same sign, the result magnitude is the sum of the two magnitudes and the result keeps that common sign.
- R3: When the operands have opposite signs, the result magnitude is the larger magnitude minus the smaller one. The result takes the sign of the operand with the larger magnitude.
- R4: A zero result is always coded with sign 0. This holds for equal magnitudes of opposite sign and for negative-zero inputs.
- R5: The final result is the sum of (A+B) and (C+D), each formed as in R2 to R4, in that pairing.
- R6: `outDone` is high exactly two clock edges after each edge where `inValid` is high, and at no other time. Valid strobes on consecutive cycles each produce their own result.
- R7: A magnitude sum that exceeds 2^(W-1)-1 wraps modulo 2^(W-1) at each adder level.
- R8: While `outDone` is low, `outSum` holds the last result, even when the operand inputs change.
- R9: While reset is asserted, `outDone` is 0 and `outSum` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands A to D are valid in this cycle |
| opA | input | W | Operand A, sign-magnitude |
| opB | input | W | Operand B, sign-magnitude |
| opC | input | W | Operand C, sign-magnitude |
| opD | input | W | Operand D, sign-magnitude |
| outDone | output | 1 | Result strobe, two cycles after inValid |
| outSum | output | W | Sign-magnitude sum of the four operands |

## Verification
The assertions check the following on every cycle:
- the two-cycle strobe timing, in both directions;
- that no negative zero ever leaves the block;
- that the result holds between strobes;
- the reset values.

The arithmetic can only be shown by the bench's scenarios. These scenarios compare results against a reference model: the three sign cases, cancellation to zero, magnitude wraparound, and the A+B / C+D pairing, which matters once a partial sum wraps.

// File: rtl/smadd_pkg.sv
package smadd_pkg;
  // Strobes the control stage hands to the datapath each cycle
  typedef struct packed {
    logic capL1;  // capture level-1 partial sums
    logic capL2;  // capture the final sum
  } addStrobe_t;
endpackage

// File: rtl/sm_ext_add.sv
// Two-input sign-magnitude adder with explicit sign-case decode (R2, R3, R4, R7)
module sm_ext_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] opX,
  input  logic [W-1:0] opY,
  output logic [W-1:0] res
);
  localparam int MW = W - 1;

  logic          sx, sy, sr;
  logic [MW-1:0] mx, my, mr;

  assign sx = opX[W-1];
  assign sy = opY[W-1];
  assign mx = opX[MW-1:0];
  assign my = opY[MW-1:0];

  always_comb begin
    if (sx == sy) begin
      // both positive or both negative: magnitudes add, wrap on overflow
      mr = mx + my;
      sr = sx;
    end else if (mx >= my) begin
      mr = mx - my;
      sr = sx;
    end else begin
      mr = my - mx;
      sr = sy;
    end
    if (mr == '0) sr = 1'b0;  // no negative zero
  end

  assign res = {sr, mr};
endmodule

// File: rtl/sm_add_ctrl.sv
// Valid pipeline: produces the capture strobes and the done pulse (R6)
module sm_add_ctrl
  import smadd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output addStrobe_t strobe,
  output logic       doneOut
);
  logic stage1Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      doneOut     <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      doneOut     <= stage1Valid;
    end
  end

  always_comb begin
    strobe.capL1 = inValid;
    strobe.capL2 = stage1Valid;
  end
endmodule

// File: rtl/sm_add_path.sv
// Two-level registered adder tree: (A+B) and (C+D), then their sum (R5, R8)
module sm_add_path
  import smadd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  addStrobe_t   strobe,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opC,
  input  logic [W-1:0] opD,
  output logic [W-1:0] sumOut
);
  localparam int NTERM  = 4;
  localparam int NPAIR  = NTERM / 2;

  logic [W-1:0] terms   [NTERM];
  logic [W-1:0] pairSum [NPAIR];
  logic [W-1:0] pairReg [NPAIR];
  logic [W-1:0] rootSum;

  assign terms[0] = opA;
  assign terms[1] = opB;
  assign terms[2] = opC;
  assign terms[3] = opD;

  for (genvar p = 0; p < NPAIR; p++) begin : gLevel1
    sm_ext_add #(.W(W)) uAdd (
      .opX (terms[2*p]),
      .opY (terms[2*p+1]),
      .res (pairSum[p])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              pairReg[p] <= '0;
      else if (strobe.capL1) pairReg[p] <= pairSum[p];
    end
  end

  sm_ext_add #(.W(W)) uRoot (
    .opX (pairReg[0]),
    .opY (pairReg[1]),
    .res (rootSum)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sumOut <= '0;
    else if (strobe.capL2) sumOut <= rootSum;
  end
endmodule

// File: rtl/sm_sum4.sv
// Top: four-operand sign-magnitude adder tree, two-cycle latency
module sm_sum4
  import smadd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opC,
  input  logic [W-1:0] opD,
  output logic         outDone,
  output logic [W-1:0] outSum
);
  addStrobe_t strobe;

  sm_add_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .doneOut (outDone)
  );

  sm_add_path #(.W(W)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .opC    (opC),
    .opD    (opD),
    .sumOut (outSum)
  );
endmodule

// File: rtl/sm_sum4_chk.sv
module sm_sum4_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         outDone,
  input logic [W-1:0] outSum
);
  logic [1:0] sinceRst;
  logic       seenRstEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceRst <= 2'd0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  always_ff @(posedge clk) begin
    seenRstEdge <= !rstN;
    if (!rstN && seenRstEdge) begin
      a_r9_reset_values: assert (!outDone && outSum == '0)
        else $error("R9: outputs not cleared in reset");
    end
  end

  a_r6_done_follows_valid: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outDone);

  a_r6_done_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    (outDone && sinceRst == 2'd2) |-> $past(inValid, 2));

  a_r4_no_negative_zero: assert property (@(posedge clk) disable iff (!rstN)
    outSum[W-1] |-> (outSum[W-2:0] != '0));

  a_r8_hold_between_results: assert property (@(posedge clk) disable iff (!rstN)
    (!outDone && sinceRst != 2'd0) |-> $stable(outSum));
endmodule

bind sm_sum4 sm_sum4_chk #(.W(W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .outDone (outDone),
  .outSum  (outSum)
);

// File: tb/sim_sm_sum4.sv
module sim_sm_sum4;
  localparam int W = 32;
  localparam int MW = W - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [W-1:0] opA = '0, opB = '0, opC = '0, opD = '0;
  logic         outDone;
  logic [W-1:0] outSum;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // bench model of the output pipeline
  logic         p1v = 0, p2v = 0;
  logic [W-1:0] p1s = '0, p2s = '0, held = '0;
  string        p1t = "R5", p2t = "R5";

  always #5 clk = ~clk;

  sm_sum4 #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .opA(opA), .opB(opB), .opC(opC), .opD(opD),
    .outDone(outDone), .outSum(outSum)
  );

  function automatic logic [W-1:0] sm(input bit neg, input logic [MW-1:0] mag);
    return {neg, mag};
  endfunction

  function automatic logic [W-1:0] refAdd(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [MW-1:0] mx = x[MW-1:0];
    logic [MW-1:0] my = y[MW-1:0];
    logic [MW-1:0] m;
    logic s;
    if (x[W-1] == y[W-1]) begin m = mx + my; s = x[W-1]; end
    else if (mx >= my)   begin m = mx - my; s = x[W-1]; end
    else                 begin m = my - mx; s = y[W-1]; end
    if (m == '0) s = 1'b0;
    return {s, m};
  endfunction

  function automatic logic [W-1:0] refSum4(input logic [W-1:0] a, b, c, d);
    return refAdd(refAdd(a, b), refAdd(c, d));
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: check outputs at negedge, then drive next inputs
  task automatic step(input bit v, input logic [W-1:0] a, b, c, d, input string tag);
    @(negedge clk);
    check(outDone == p2v, "R6", {{(W-1){1'b0}}, outDone}, {{(W-1){1'b0}}, p2v});
    if (p2v) begin
      check(outSum == p2s, p2t, outSum, p2s);
      held = p2s;
    end else begin
      check(outSum == held, "R8", outSum, held);
    end
    inValid = v; opA = a; opB = b; opC = c; opD = d;
    p2v = p1v; p2s = p1s; p2t = p1t;
    p1v = v;   p1s = refSum4(a, b, c, d); p1t = tag;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    check(outDone == 1'b0 && outSum == '0, "R9", outSum, '0);
    rstN = 1'b1;

    // R2: all positive, all negative
    step(1, sm(0, 10), sm(0, 20), sm(0, 30), sm(0, 40), "R2");
    step(1, sm(1, 5), sm(1, 6), sm(1, 7), sm(1, 8), "R2");
    // R3: opposite signs, larger one wins
    step(1, sm(0, 100), sm(1, 30), sm(1, 200), sm(0, 50), "R3");
    step(1, sm(1, 3), sm(0, 9), sm(0, 1), sm(1, 20), "R3");
    // R4: cancellation and negative zero inputs
    step(1, sm(0, 77), sm(1, 77), sm(1, 0), sm(1, 0), "R4");
    step(1, sm(1, 12), sm(0, 4), sm(0, 8), sm(1, 0), "R4");
    // R7: magnitude wrap
    step(1, sm(0, '1), sm(0, 2), sm(0, 0), sm(0, 0), "R7");
    // R5: pairing matters once a partial sum wraps
    step(1, sm(0, '1), sm(0, 1), sm(1, 1), sm(0, 0), "R5");
    // R1: sign in top bit, negative result
    step(1, sm(0, 1), sm(0, 1), sm(1, 1000), sm(0, 0), "R1");
    // R8: valid low, inputs change, output holds
    step(0, sm(0, 999), sm(1, 5), sm(0, 6), sm(1, 7), "R8");
    step(0, sm(1, 123), sm(0, 456), sm(1, 7), sm(0, 8), "R8");
    step(0, '0, '0, '0, '0, "R8");

    // random mix with fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] r[4];
      for (int k = 0; k < 4; k++) begin
        r[k] = $urandom;
        if ($urandom_range(0, 3) == 0) r[k][MW-1:8] = '0;  // small magnitudes
      end
      step($urandom_range(0, 2) != 0, r[0], r[1], r[2], r[3], "R5");
    end
    step(0, '0, '0, '0, '0, "R8");
    step(0, '0, '0, '0, '0, "R8");
    step(0, '0, '0, '0, '0, "R8");

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule